// File: doc/BRIEF.md
# Non-Posted Request Admission Limiter

This block sits in front of the outbound read-request path of a link endpoint. It decides whether the next non-posted request may be issued. The endpoint must take every completion that comes back, but the first-stage completion store holds only a fixed number of packets. Read requests are therefore admitted only while the number of requests still waiting for their last completion is below a programmable ceiling. The ceiling is chosen so that the worst-case number of split completions those requests can produce still fits in the store.

Each accepted request adds one to a running count. When the final completion of a request arrives, its tag is flagged in a per-tag done vector, and the count drops by the number of flagged tags. A separate helper computes a recommended ceiling from the largest read request size in use and from whether request addresses are guaranteed to sit on 64-byte boundaries. Firmware or a neighbouring block can copy that value into the programmed limit.

Top module: `np_admit_limiter`

## Requirements
- R1: While reset is asserted, the outstanding count is cleared to 0 on the next clock edge, and it reads 0 after reset is released.
- R2: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. Each accepted request raises `out_count` by one in the following cycle. A cycle with `req_valid` low does not raise it.
- R3: Each bit set in `cpl_done` (bit i is the final completion of tag i) lowers `out_count` by one in the following cycle. Several bits in one cycle lower it by the number of bits set.
- R4: An accepted request in the same cycle as exactly one completion-done bit leaves `out_count` unchanged.
- R5: `req_ready` is high exactly when `out_count` is below the effective limit. With `req_valid` held high, the count stops at the limit.
- R6: A programmed limit of 0 holds `req_ready` low, and no request is accepted.
- R7: A programmed limit above 128 acts as 128, so at most 128 requests are outstanding.
- R8: The count saturates at 0. Completion-done bits in excess of the count, including any while the count is 0, leave it at 0.
- R9: `rec_limit` equals min(128, floor(256 / splits)). Here splits = 2^code + u, `code` = `rd_size_code` (0 = 64 B, 1 = 128 B, up to 6 = 4096 B; code 7 is treated as 6), and u = 1 when `rd_unaligned` is high. Examples: 128 B unaligned gives 85, 256 B aligned gives 64, 4096 B unaligned gives 3, and 64 B either way gives 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A read request wants to issue |
| req_ready | output | 1 | Request may issue this cycle |
| lim_cfg | input | 8 | Programmed outstanding-request ceiling |
| cpl_done | input | 128 | Per-tag flag: final completion received this cycle |
| out_count | output | 8 | Requests awaiting their final completion |
| rd_size_code | input | 3 | Largest read request size, log2(bytes/64) |
| rd_unaligned | input | 1 | Request addresses may be off a 64-byte boundary |
| rec_limit | output | 8 | Recommended ceiling for the given size and alignment |

## Verification
`req_ready` and `rec_limit` are combinational. They are due in the same cycle as the inputs that set them, so the bench drives the inputs just after a rising edge and samples these outputs one nanosecond later, before the next edge. `out_count` is a single register. An acceptance or completion in one cycle shows up at the next rising edge, so the bench compares the count just after that edge against a model that advances exactly once per edge. Each scenario runs the count up to a ceiling and back down, so that the saturating and clamped boundaries are hit at their exact cycle.

// File: rtl/np_adm_pkg.sv
package np_adm_pkg;

    // Capacity of the first-stage completion store, in packets.
    localparam int unsigned CPL_SLOTS   = 256;
    // Largest number of requests that may ever be outstanding.
    localparam int unsigned MAX_NP      = 128;
    // Largest legal size code (64 B << code).
    localparam int unsigned SIZE_CODE_HI = 6;

    typedef logic [2:0] size_code_t;

    // Shape of the worst-case read request.
    typedef struct packed {
        size_code_t code;
        logic       unaligned;
    } rd_shape_t;

    // Worst-case completion packets produced by one request of this shape.
    function automatic int unsigned worst_splits(rd_shape_t s);
        int unsigned c;
        c = (int'(s.code) > SIZE_CODE_HI) ? SIZE_CODE_HI : int'(s.code);
        return (32'd1 << c) + (s.unaligned ? 32'd1 : 32'd0);
    endfunction

    // Largest request count whose splits all fit, capped at 'cap'.
    function automatic int unsigned fit_limit(int unsigned splits,
                                              int unsigned slots,
                                              int unsigned cap);
        int unsigned q;
        q = slots / splits;
        return (q > cap) ? cap : q;
    endfunction

endpackage

// File: rtl/np_limit_calc.sv
module np_limit_calc
    import np_adm_pkg::*;
#(
    parameter int unsigned LIM_W     = 8,
    parameter int unsigned BUF_SLOTS = CPL_SLOTS,
    parameter int unsigned MAX_OUT   = MAX_NP
) (
    input  size_code_t       size_code,
    input  logic             unaligned,
    output logic [LIM_W-1:0] rec_limit
);
    rd_shape_t   shape;
    int unsigned splits;
    int unsigned lim;

    always_comb begin
        shape.code      = size_code;
        shape.unaligned = unaligned;
        splits          = worst_splits(shape);
        lim             = fit_limit(splits, BUF_SLOTS, MAX_OUT);
        rec_limit       = LIM_W'(lim);
    end
endmodule

// File: rtl/np_admit_gate.sv
module np_admit_gate #(
    parameter int unsigned LIM_W   = 8,
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned MAX_OUT = 128
) (
    input  logic [LIM_W-1:0] lim_cfg,
    input  logic [CNT_W-1:0] count,
    input  logic             req_valid,
    output logic             req_ready,
    output logic             fire
);
    localparam int unsigned W = ((LIM_W > CNT_W) ? LIM_W : CNT_W) + 1;

    logic [W-1:0] cap_w;
    logic [W-1:0] cfg_w;
    logic [W-1:0] eff_w;
    logic [W-1:0] cnt_w;

    always_comb begin
        cap_w     = W'(MAX_OUT);
        cfg_w     = W'(lim_cfg);
        cnt_w     = W'(count);
        eff_w     = (cfg_w > cap_w) ? cap_w : cfg_w;
        req_ready = (cnt_w < eff_w);
        fire      = req_valid & req_ready;
    end
endmodule

// File: rtl/np_outstanding_ctr.sv
module np_outstanding_ctr #(
    parameter int unsigned NTAG  = 128,
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic [NTAG-1:0]  done_vec,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W:0]   pop;
    logic [CNT_W:0]   raised;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        pop = '0;
        for (int i = 0; i < int'(NTAG); i++) begin
            pop = pop + (CNT_W+1)'(done_vec[i]);
        end
    end

    always_comb begin
        raised = {1'b0, count} + (CNT_W+1)'(inc);
        if (pop >= raised) nxt = '0;
        else               nxt = CNT_W'(raised - pop);
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= nxt;
    end
endmodule

// File: rtl/np_admit_limiter.sv
module np_admit_limiter
    import np_adm_pkg::*;
#(
    parameter int unsigned LIM_W     = 8,
    parameter int unsigned MAX_OUT   = MAX_NP,
    parameter int unsigned BUF_SLOTS = CPL_SLOTS,
    parameter int unsigned NTAG      = MAX_OUT,
    parameter int unsigned CNT_W     = $clog2(MAX_OUT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [LIM_W-1:0] lim_cfg,
    input  logic [NTAG-1:0]  cpl_done,
    output logic [CNT_W-1:0] out_count,
    input  logic [2:0]       rd_size_code,
    input  logic             rd_unaligned,
    output logic [LIM_W-1:0] rec_limit
);
    logic fire;

    np_admit_gate #(.LIM_W(LIM_W), .CNT_W(CNT_W), .MAX_OUT(MAX_OUT)) u_gate (
        .lim_cfg   (lim_cfg),
        .count     (out_count),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .fire      (fire)
    );

    np_outstanding_ctr #(.NTAG(NTAG), .CNT_W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .inc      (fire),
        .done_vec (cpl_done),
        .count    (out_count)
    );

    np_limit_calc #(.LIM_W(LIM_W), .BUF_SLOTS(BUF_SLOTS), .MAX_OUT(MAX_OUT)) u_calc (
        .size_code (rd_size_code),
        .unaligned (rd_unaligned),
        .rec_limit (rec_limit)
    );
endmodule

// File: rtl/np_admit_limiter_chk.sv
module np_admit_limiter_chk #(
    parameter int unsigned LIM_W   = 8,
    parameter int unsigned MAX_OUT = 128,
    parameter int unsigned NTAG    = 128,
    parameter int unsigned CNT_W   = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [LIM_W-1:0] lim_cfg,
    input logic [NTAG-1:0]  cpl_done,
    input logic [CNT_W-1:0] out_count,
    input logic [LIM_W-1:0] rec_limit
);
    logic acc;
    assign acc = req_valid && req_ready;

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (out_count == '0));

    a_r2_accept_inc: assert property (@(posedge clk) disable iff (rst)
        (acc && (cpl_done == '0)) |=> (out_count == CNT_W'($past(out_count) + 1'b1)));

    a_r3_done_dec: assert property (@(posedge clk) disable iff (rst)
        (!acc && ($countones(cpl_done) == 1) && (out_count != '0))
        |=> (out_count == CNT_W'($past(out_count) - 1'b1)));

    a_r4_balance: assert property (@(posedge clk) disable iff (rst)
        (acc && ($countones(cpl_done) == 1)) |=> $stable(out_count));

    a_r5_full_block: assert property (@(posedge clk) disable iff (rst)
        (int'(out_count) >= int'(lim_cfg)) |-> !req_ready);

    a_r6_zero_block: assert property (@(posedge clk) disable iff (rst)
        (lim_cfg == '0) |-> !req_ready);

    a_r7_cap: assert property (@(posedge clk) disable iff (rst)
        (int'(out_count) <= int'(MAX_OUT)));

    a_r8_floor: assert property (@(posedge clk) disable iff (rst)
        ((out_count == '0) && !acc) |=> (out_count == '0));

    a_r9_rec_range: assert property (@(posedge clk) disable iff (rst)
        (rec_limit != '0) && (int'(rec_limit) <= int'(MAX_OUT)));
endmodule

bind np_admit_limiter np_admit_limiter_chk #(
    .LIM_W(LIM_W), .MAX_OUT(MAX_OUT), .NTAG(NTAG), .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .lim_cfg   (lim_cfg),
    .cpl_done  (cpl_done),
    .out_count (out_count),
    .rec_limit (rec_limit)
);

// File: tb/np_admit_limiter_tb.sv
`timescale 1ns/1ps
module np_admit_limiter_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [7:0]   lim_cfg = 8'd0;
    logic [127:0] cpl_done = '0;
    logic [7:0]   out_count;
    logic [2:0]   rd_size_code = 3'd0;
    logic         rd_unaligned = 1'b0;
    logic [7:0]   rec_limit;

    int n_chk  = 0;
    int n_fail = 0;
    int model  = 0;

    always #4 clk = ~clk;

    np_admit_limiter u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .lim_cfg(lim_cfg), .cpl_done(cpl_done), .out_count(out_count),
        .rd_size_code(rd_size_code), .rd_unaligned(rd_unaligned), .rec_limit(rec_limit)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Drive one cycle of stimulus; check ready now and count after the edge.
    task automatic step(input logic v, input logic [127:0] vec, input string tag);
        int eff, rdy, fire, pop, up;
        req_valid = v;
        cpl_done  = vec;
        #1;
        eff  = (lim_cfg > 8'd128) ? 128 : int'(lim_cfg);
        rdy  = (model < eff) ? 1 : 0;
        chk({tag, " ready"}, int'(req_ready), rdy);
        fire = (v && rdy) ? 1 : 0;
        pop  = $countones(vec);
        up   = model + fire;
        model = (pop >= up) ? 0 : up - pop;
        tick();
        chk({tag, " count"}, int'(out_count), model);
    endtask

    task automatic t_reset();
        rst = 1'b1; req_valid = 1'b0; cpl_done = '0; lim_cfg = 8'd4;
        tick(); tick();
        rst = 1'b0; model = 0;
        #1;
        chk("R1 count after reset", int'(out_count), 0);
        chk("R1 ready after reset", int'(req_ready), 1);
    endtask

    task automatic t_fill_small();
        lim_cfg = 8'd3;
        step(1'b0, '0, "R2 idle");
        for (int i = 0; i < 5; i++) step(1'b1, '0, "R2/R5 fill");
        chk("R5 held at limit", int'(out_count), 3);
        chk("R5 ready low", int'(req_ready), 0);
    endtask

    task automatic t_done();
        step(1'b0, 128'h5, "R3 two done");
        chk("R3 count after two", int'(out_count), 1);
        step(1'b1, 128'h8, "R4 balance");
        chk("R4 unchanged", int'(out_count), 1);
        step(1'b0, 128'h1, "R3 one done");
    endtask

    task automatic t_zero();
        lim_cfg = 8'd0;
        for (int i = 0; i < 3; i++) step(1'b1, '0, "R6 zero limit");
        chk("R6 nothing accepted", int'(out_count), 0);
    endtask

    task automatic t_big();
        lim_cfg = 8'd200;
        for (int i = 0; i < 131; i++) step(1'b1, '0, "R7 fill");
        chk("R7 clamped at 128", int'(out_count), 128);
        lim_cfg = 8'd255;
        step(1'b1, '0, "R7 max cfg");
        step(1'b0, {128{1'b1}}, "R8 drain all");
        chk("R8 drained", int'(out_count), 0);
        step(1'b0, 128'hF0, "R8 extra done");
        chk("R8 floor", int'(out_count), 0);
        lim_cfg = 8'd2;
        step(1'b1, '0, "R2 one");
        step(1'b0, 128'h3, "R8 over by one");
        chk("R8 saturate", int'(out_count), 0);
    endtask

    task automatic t_calc();
        int c, sp, e;
        for (int code = 0; code < 8; code++) begin
            for (int u = 0; u < 2; u++) begin
                rd_size_code = 3'(code);
                rd_unaligned = (u != 0);
                #1;
                c  = (code > 6) ? 6 : code;
                sp = (1 << c) + u;
                e  = 256 / sp;
                if (e > 128) e = 128;
                chk($sformatf("R9 code %0d u %0d", code, u), int'(rec_limit), e);
            end
        end
        rd_size_code = 3'd1; rd_unaligned = 1'b1; #1;
        chk("R9 128B unaligned", int'(rec_limit), 85);
        rd_size_code = 3'd2; rd_unaligned = 1'b0; #1;
        chk("R9 256B aligned", int'(rec_limit), 64);
        rd_size_code = 3'd6; rd_unaligned = 1'b1; #1;
        chk("R9 4096B unaligned", int'(rec_limit), 3);
    endtask

    initial begin
        t_reset();
        t_fill_small();
        t_done();
        t_zero();
        t_big();
        t_calc();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule